// File: doc/BRIEF.md
# General-Purpose Bidirectional I/O Port

This block controls one port of general-purpose pins from a small register bus. Software sets each pin's direction, sets the level an output pin drives, and reads back the synchronised pad levels. For an input pin, the output-level bit instead turns on a pull-up. A chip-wide pull-up disable input can switch every pull-up off at once. A sleep input forces the sampled pad levels to zero, so floating pads do not toggle logic while the chip sleeps.

Each pin has three outputs toward a pad cell: an output enable, an output level and a pull-up enable. It takes one raw, asynchronous pad level back from the pad. Two flip-flops bring each pad level into the clock domain.

Writes to the third address do not store a value. Each 1 in the written data flips the matching output bit, so software can toggle pins without a read-modify-write. Reset is asynchronous. It tri-states every pin and drops every pull-up without any clock edge.

Top module: `gpio_port`

## Requirements
- R1: A write to address 0 stores `wdata` as the direction bits. A 1 bit makes that pin an output, so `pad_oe` equals the stored direction bits.
- R2: A write to address 1 stores `wdata` as the output bits, and `pad_out` equals the stored output bits.
- R3: `pad_pu[i]` is 1 exactly when pin i is an input (direction bit 0), its output bit is 1 and `pull_disable` is 0.
- R4: While `pull_disable` is 1, every bit of `pad_pu` is 0, whatever the direction and output bits hold.
- R5: A high level on `rst` clears the direction bits, the output bits and the synchroniser at once, with no clock edge needed. After reset, `pad_oe` and `pad_pu` are all zero.
- R6: A change of `pad_in` that is stable before a rising clock edge appears on the pin readback after the second rising edge, and does not appear after the first.
- R7: A write to address 2 flips each output bit whose `wdata` bit is 1 and leaves each output bit whose `wdata` bit is 0 unchanged.
- R8: While `sleep` is 1, the pin readback is all zero. `pad_oe`, `pad_out` and `pad_pu` are not affected by `sleep`.
- R9: `rdata` is combinational and depends on the read strobes:
  - with `rd_dir` high, it returns the direction bits;
  - otherwise, with `rd_out` high, it returns the output bits;
  - otherwise, with `rd_pin` high, it returns the pin readback;
  - with no strobe high, it is zero.
- R10: A write to address 3 changes neither the direction bits nor the output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Asynchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Write address: 0 direction, 1 output, 2 toggle, 3 unused |
| wdata | input | 8 | Write data |
| rd_dir | input | 1 | Read strobe for the direction bits |
| rd_out | input | 1 | Read strobe for the output bits |
| rd_pin | input | 1 | Read strobe for the synchronised pad levels |
| rdata | output | 8 | Read data |
| pull_disable | input | 1 | Chip-wide pull-up disable |
| sleep | input | 1 | Forces the pin readback to zero |
| pad_in | input | 8 | Raw asynchronous pad levels |
| pad_oe | output | 8 | Per-pin output driver enable |
| pad_out | output | 8 | Per-pin driven level |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The properties assume the following about the inputs:
- `wr_en`, `addr`, `wdata` and the read strobes change only away from the rising clock edge;
- `pull_disable` and `sleep` are treated as synchronous levels.

Nothing is assumed about `pad_in` timing, because it passes through the synchroniser. The stimulus meets these assumptions by driving every bus and control input on the falling edge. It samples results halfway through the low phase. It changes the pad model's level only on falling edges, so every latency count starts from a known rising edge. The clockless reset check stops the clock at a falling edge and restarts it at a later one, so gating the clock never creates a spurious rising edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR  = 2'd0,
        SEL_OUT  = 2'd1,
        SEL_FLIP = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SRC_ZERO,
        SRC_DIR,
        SRC_OUT,
        SRC_PIN
    } rd_src_e;

    // Fixed priority among the read strobes: direction, output, pin.
    function automatic rd_src_e pick_source(input logic s_dir,
                                            input logic s_out,
                                            input logic s_pin);
        if (s_dir)      return SRC_DIR;
        else if (s_out) return SRC_OUT;
        else if (s_pin) return SRC_PIN;
        else            return SRC_ZERO;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      out_q
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            dir_q <= '0;
        end else if (wr_en && sel == SEL_DIR) begin
            dir_q <= wdata;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            out_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_OUT:  out_q <= wdata;
                SEL_FLIP: out_q <= out_q ^ wdata;
                default:  out_q <= out_q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sleep,
    input  logic [W-1:0] raw,
    output logic [W-1:0] level
);

    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or posedge rst) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or posedge rst) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign level = sleep ? '0 : chain[STAGES-1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] out_q,
    input  logic         pull_disable,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pad_oe[i]  = dir_q[i];
        assign pad_out[i] = out_q[i];
        assign pad_pu[i]  = !dir_q[i] && out_q[i] && !pull_disable;
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic              rd_dir,
    input  logic              rd_out,
    input  logic              rd_pin,
    output logic [W-1:0]      rdata,
    input  logic              pull_disable,
    input  logic              sleep,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_pu
);

    logic [W-1:0] dir_q;
    logic [W-1:0] out_q;
    logic [W-1:0] pin_level;
    rd_src_e      src;

    gpio_regs #(.W(W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .dir_q (dir_q),
        .out_q (out_q)
    );

    gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .sleep (sleep),
        .raw   (pad_in),
        .level (pin_level)
    );

    gpio_pad_ctrl #(.W(W)) u_pad (
        .dir_q        (dir_q),
        .out_q        (out_q),
        .pull_disable (pull_disable),
        .pad_oe       (pad_oe),
        .pad_out      (pad_out),
        .pad_pu       (pad_pu)
    );

    assign src = pick_source(rd_dir, rd_out, rd_pin);

    always_comb begin
        case (src)
            SRC_DIR: rdata = dir_q;
            SRC_OUT: rdata = out_q;
            SRC_PIN: rdata = pin_level;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [1:0]   addr,
    input logic [W-1:0] wdata,
    input logic         rd_dir,
    input logic         rd_out,
    input logic         rd_pin,
    input logic [W-1:0] rdata,
    input logic         pull_disable,
    input logic         sleep,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_out,
    input logic [W-1:0] pad_pu
);

    assert_dir_write_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd0) |=> pad_oe == $past(wdata));

    assert_pullup_rule_R3: assert property (@(posedge clk) disable iff (rst)
        pad_pu == (~pad_oe & pad_out & {W{!pull_disable}}));

    assert_pull_off_R4: assert property (@(posedge clk) disable iff (rst)
        pull_disable |-> pad_pu == '0);

    assert_reset_state_R5: assert property (@(posedge clk)
        rst |-> (pad_oe == '0 && pad_pu == '0 && pad_out == '0));

    assert_flip_write_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd2) |=> pad_out == ($past(pad_out) ^ $past(wdata)));

    assert_sleep_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (sleep && rd_pin && !rd_dir && !rd_out) |-> rdata == '0);

    assert_unused_addr_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd3) |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .rd_dir       (rd_dir),
    .rd_out       (rd_out),
    .rd_pin       (rd_pin),
    .rdata        (rdata),
    .pull_disable (pull_disable),
    .sleep        (sleep),
    .pad_oe       (pad_oe),
    .pad_out      (pad_out),
    .pad_pu       (pad_pu)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;

    logic       clk_raw = 1'b0;
    logic       clk_run = 1'b1;
    logic       clk;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rd_dir = 1'b0, rd_out = 1'b0, rd_pin = 1'b0;
    logic [7:0] rdata;
    logic       pull_disable = 1'b0;
    logic       sleep = 1'b0;
    logic [7:0] drv = '0;
    logic [7:0] pad_in, pad_oe, pad_out, pad_pu;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    always #5 clk_raw = ~clk_raw;
    assign clk = clk_raw & clk_run;

    // Pad model: driven level, else pull-up, else external level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & pad_pu) | (~pad_oe & ~pad_pu & drv);

    gpio_port u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_dir(rd_dir), .rd_out(rd_out), .rd_pin(rd_pin), .rdata(rdata),
        .pull_disable(pull_disable), .sleep(sleep), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] out;
        logic [7:0] ext;
        logic       pud;
        logic [7:0] exp_pu;
        logic [7:0] exp_pin;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 8'hA5, 1'b0, 8'h00, 8'hA5},
        '{8'hFF, 8'h3C, 8'h00, 1'b0, 8'h00, 8'h3C},
        '{8'h0F, 8'hF0, 8'h00, 1'b0, 8'hF0, 8'hF0},
        '{8'h0F, 8'hF0, 8'h00, 1'b1, 8'h00, 8'h00},
        '{8'h0F, 8'h5A, 8'h81, 1'b0, 8'h50, 8'hDA},
        '{8'hAA, 8'hFF, 8'h00, 1'b0, 8'h55, 8'hFF}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk_raw);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk_raw);
        wr_en = 1'b0;
    endtask

    // 0 = direction, 1 = output, 2 = pin, 3 = no strobe
    task automatic rd(input int which, output logic [7:0] v);
        rd_dir = (which == 0);
        rd_out = (which == 1);
        rd_pin = (which == 2);
        #1 v = rdata;
        rd_dir = 1'b0; rd_out = 1'b0; rd_pin = 1'b0;
        #1;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk_raw);
        // R5: reset state
        check("R5 oe", pad_oe, 8'h00);
        check("R5 pu", pad_pu, 8'h00);
        rst = 1'b0;
        @(negedge clk_raw);
        rd(0, v); check("R5 dir", v, 8'h00);
        rd(1, v); check("R5 out", v, 8'h00);

        // Table of configurations (R1, R2, R3, R4, R6)
        for (int k = 0; k < NV; k++) begin
            wr(2'd0, VECS[k].dir);
            wr(2'd1, VECS[k].out);
            pull_disable = VECS[k].pud;
            drv = VECS[k].ext;
            repeat (3) @(negedge clk_raw);
            check("R1 oe", pad_oe, VECS[k].dir);
            check("R2 out", pad_out, VECS[k].out);
            check(VECS[k].pud ? "R4 pu" : "R3 pu", pad_pu, VECS[k].exp_pu);
            rd(2, v); check("R6 pin", v, VECS[k].exp_pin);
        end
        pull_disable = 1'b0;

        // R6: two-edge latency
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); drv = 8'h00;
        repeat (3) @(negedge clk_raw);
        drv = 8'hFF;
        @(negedge clk_raw);
        rd(2, v); check("R6 one edge", v, 8'h00);
        @(negedge clk_raw);
        rd(2, v); check("R6 two edges", v, 8'hFF);

        // R7: toggle writes
        wr(2'd0, 8'hFF); wr(2'd1, 8'h0F);
        wr(2'd2, 8'h3C);
        rd(1, v); check("R7 flip", v, 8'h33);
        wr(2'd2, 8'h00);
        rd(1, v); check("R7 zero no change", v, 8'h33);

        // R8: sleep gating
        wr(2'd0, 8'h0F); wr(2'd1, 8'hA5); drv = 8'h00;
        repeat (3) @(negedge clk_raw);
        rd(2, v); check("R8 awake pin", v, 8'hA5);
        sleep = 1'b1;
        @(negedge clk_raw);
        rd(2, v); check("R8 sleep pin", v, 8'h00);
        check("R8 oe", pad_oe, 8'h0F);
        check("R8 out", pad_out, 8'hA5);
        check("R8 pu", pad_pu, 8'hA0);
        sleep = 1'b0;

        // R9: strobe priority and idle
        rd_dir = 1'b1; rd_out = 1'b1; rd_pin = 1'b1;
        #1 check("R9 priority dir", rdata, 8'h0F);
        rd_dir = 1'b0;
        #1 check("R9 priority out", rdata, 8'hA5);
        rd_out = 1'b0; rd_pin = 1'b0;
        #1 check("R9 idle", rdata, 8'h00);

        // R10: unused address
        wr(2'd3, 8'h77);
        rd(0, v); check("R10 dir", v, 8'h0F);
        rd(1, v); check("R10 out", v, 8'hA5);

        // R5: asynchronous reset with clock stopped
        wr(2'd0, 8'hF0); wr(2'd1, 8'hFF);
        @(negedge clk_raw);
        clk_run = 1'b0;
        #3 rst = 1'b1;
        #1;
        check("R5 async oe", pad_oe, 8'h00);
        check("R5 async out", pad_out, 8'h00);
        check("R5 async pu", pad_pu, 8'h00);
        rd(2, v); check("R5 async pin", v, 8'h00);
        #20 rst = 1'b0;
        @(negedge clk_raw);
        clk_run = 1'b1;
        repeat (2) @(negedge clk_raw);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule